// File: doc/BRIEF.md
# Power Mode State Controller

This block decides which of three power modes a system-on-chip is in: standby, operating or idle. It drives a hold on the CPU reset, an enable for the CPU clock, and a two-bit code for the current mode. Two kinds of event start the system from standby. One is an interrupt request. The other is a rising edge on an asynchronous wake-up pin, which the block synchronizes first. Either start only takes effect when the supply inputs show that power is adequate. After a start, the CPU stays in reset with its clock gated for a fixed number of cycles before it runs.

While operating, software can move the block to standby or to idle by writing to one of two decoded locations. Each such write reaches the block as a single-cycle strobe. A power-fail event or a user reset forces standby from any running mode. From idle, an interrupt resumes operation at once. There is no warm-up on that path because the CPU was never reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode output is 2'b00 (standby), `cpu_rst_hold` is 1 and `cpu_clk_en` is 0. In standby these two outputs always keep those values.
- R2: A start from standby is accepted only when the supply is adequate. The supply is adequate when `ext_pwr_n` is 0, or when both `batt_ok` and `supply_good` are 1. A start request made while the supply is not adequate is dropped, and the mode stays 2'b00.
- R3: In standby, with an adequate supply, any bit of `irq` that is high at a clock edge changes the mode to 2'b01 (operating) at that edge.
- R4: `wake_pin` goes through a two-flop synchronizer. Suppose the pin rises before clock edge k. With an adequate supply, the mode becomes 2'b01 at edge k+2. If the pin is held high, it does not start the block again.
- R5: On entry to operating from standby, `cpu_rst_hold` stays 1 and `cpu_clk_en` stays 0 for WAKE_DELAY cycles (8 by default). After that, `cpu_rst_hold` is 0 and `cpu_clk_en` is 1.
- R6: In operating, a `standby_wr` strobe, `pwr_fail` or `user_rst` returns the mode to 2'b00 at the next edge.
- R7: In operating, after the warm-up, a `halt_wr` strobe moves the mode to 2'b10 (idle). In idle, `cpu_clk_en` is 0 and `cpu_rst_hold` is 0.
- R8: In idle, an interrupt moves the mode to 2'b01 with `cpu_clk_en` 1 at that edge, with no warm-up. `pwr_fail` or `user_rst` moves the mode to 2'b00.
- R9: `pwr_fail` and `user_rst` take priority over an interrupt or a halt strobe in the same cycle. In operating, `standby_wr` takes priority over `halt_wr`.
- R10: In standby, `pwr_fail` or `user_rst` blocks a start even when an interrupt is present and the supply is adequate.
- R11: During the warm-up, `halt_wr` and `standby_wr` are ignored and the mode stays 2'b01. `pwr_fail` and `user_rst` still return the block to standby.
- R12: The mode output never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pwr_n | input | 1 | Low when external power is present |
| batt_ok | input | 1 | High when the main battery is adequate |
| supply_good | input | 1 | High when no power-fail condition is present on the supply |
| pwr_fail | input | 1 | Power-fail event, forces standby |
| user_rst | input | 1 | User reset request, forces standby |
| wake_pin | input | 1 | Asynchronous wake-up pin, acts on its rising edge |
| irq | input | IRQ_W | Interrupt requests |
| standby_wr | input | 1 | Decoded write strobe to the standby location |
| halt_wr | input | 1 | Decoded write strobe to the halt location |
| cpu_rst_hold | output | 1 | Holds the CPU in reset |
| cpu_clk_en | output | 1 | Enables the CPU clock |
| mode | output | 2 | Current mode: 00 standby, 01 operating, 10 idle |

## Verification
The assertions check the following on every cycle:
- the mode is never 2'b11;
- the output levels are correct in standby and in idle;
- every entry to operating from standby happened with an adequate supply;
- power fail or user reset in a running mode always leads to standby;
- the warm-up cannot be left except through standby.

Other behaviour can only be shown by the bench's scenarios:
- the exact length of the warm-up;
- the two-cycle latency of the wake-up synchronizer, and that a held pin does not start the block again;
- the resume from idle with no warm-up;
- the result of each start attempt across all eight supply combinations.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int IRQ_W       = 4,
  parameter int WAKE_DELAY  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pwr_n,
  input  logic             batt_ok,
  input  logic             supply_good,
  input  logic             pwr_fail,
  input  logic             user_rst,
  input  logic             wake_pin,
  input  logic [IRQ_W-1:0] irq,
  input  logic             standby_wr,
  input  logic             halt_wr,
  output logic             cpu_rst_hold,
  output logic             cpu_clk_en,
  output logic [1:0]       mode
);

  localparam int CW = $clog2(WAKE_DELAY + 1);
  localparam logic [1:0] M_STBY = 2'b00;
  localparam logic [1:0] M_OPER = 2'b01;
  localparam logic [1:0] M_IDLE = 2'b10;

  logic [SYNC_STAGES:0] wake_sh;
  logic [CW-1:0]        cnt;
  logic [1:0]           nxt;

  wire wake_rise = wake_sh[SYNC_STAGES-1] & ~wake_sh[SYNC_STAGES];
  wire any_irq   = |irq;
  wire kill      = pwr_fail | user_rst;
  wire supply_ok = ~ext_pwr_n | (batt_ok & supply_good);
  wire warming   = cnt != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wake_sh <= '0;
    else        wake_sh <= {wake_sh[SYNC_STAGES-1:0], wake_pin};

  always_comb begin
    nxt = mode;
    unique case (mode)
      M_STBY: if (!kill && supply_ok && (any_irq || wake_rise)) nxt = M_OPER;
      M_OPER: if (kill || (!warming && standby_wr)) nxt = M_STBY;
              else if (!warming && halt_wr)         nxt = M_IDLE;
      M_IDLE: if (kill)         nxt = M_STBY;
              else if (any_irq) nxt = M_OPER;
      default: nxt = M_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_STBY;
      cnt  <= '0;
    end else begin
      mode <= nxt;
      if (mode == M_STBY && nxt == M_OPER) cnt <= CW'(WAKE_DELAY);
      else if (nxt == M_STBY)              cnt <= '0;
      else if (warming)                    cnt <= cnt - 1'b1;
    end

  assign cpu_rst_hold = (mode == M_STBY) | warming;
  assign cpu_clk_en   = (mode == M_OPER) & ~warming;

  assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  assert_standby_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_STBY |-> cpu_rst_hold && !cpu_clk_en);

  assert_idle_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_IDLE |-> !cpu_rst_hold && !cpu_clk_en);

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OPER && $past(mode) == M_STBY) |->
      ($past(supply_ok) && !$past(kill) && cpu_rst_hold));

  assert_kill_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_STBY && kill) |=> mode == M_STBY);

  assert_warmup_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OPER && cpu_rst_hold && !kill) |=> mode == M_OPER);

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int IRQ_W = 4;
  localparam int WD    = 8;

  logic clk = 0, rst_n = 0;
  logic ext_pwr_n = 1, batt_ok = 0, supply_good = 0;
  logic pwr_fail = 0, user_rst = 0, wake_pin = 0;
  logic [IRQ_W-1:0] irq = '0;
  logic standby_wr = 0, halt_wr = 0;
  logic cpu_rst_hold, cpu_clk_en;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.IRQ_W(IRQ_W), .WAKE_DELAY(WD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pwr_n(ext_pwr_n), .batt_ok(batt_ok),
    .supply_good(supply_good), .pwr_fail(pwr_fail), .user_rst(user_rst),
    .wake_pin(wake_pin), .irq(irq), .standby_wr(standby_wr), .halt_wr(halt_wr),
    .cpu_rst_hold(cpu_rst_hold), .cpu_clk_en(cpu_clk_en), .mode(mode));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int m, input int rh, input int ce);
    chk(req, mode, m);
    chk(req, cpu_rst_hold, rh);
    chk(req, cpu_clk_en, ce);
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic to_standby();
    user_rst = 1; cyc(); user_rst = 0; cyc();
  endtask

  task automatic good_supply();
    ext_pwr_n = 1; batt_ok = 1; supply_good = 1;
  endtask

  task automatic start_and_warm();
    irq = 4'b0001; cyc(); irq = '0;
    for (int i = 0; i < WD; i++) cyc();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    chk_out("R1 in reset", 0, 1, 0);
    rst_n = 1; cyc(); cyc();
    chk_out("R1 after reset", 0, 1, 0);

    // R2/R3/R5: sweep all supply combinations, start by interrupt
    for (int s = 0; s < 8; s++) begin
      {ext_pwr_n, batt_ok, supply_good} = 3'(s);
      irq = 4'(1 << (s % IRQ_W));
      cyc();
      irq = '0;
      if (((s >> 2) & 1) == 0 || (s & 3) == 3) begin
        chk("R2 R3 start accepted", mode, 1);
        for (int i = 0; i < WD; i++) begin
          chk("R5 warm-up reset hold", cpu_rst_hold, 1);
          chk("R5 warm-up clock gated", cpu_clk_en, 0);
          cyc();
        end
        chk_out("R5 warm-up done", 1, 0, 1);
      end else begin
        chk_out("R2 start refused", 0, 1, 0);
      end
      to_standby();
      chk("R6 user reset to standby", mode, 0);
    end

    // R4: wake pin through synchronizer
    good_supply();
    wake_pin = 1;
    cyc(); chk("R4 sync stage 1", mode, 0);
    cyc(); chk("R4 sync stage 2", mode, 0);
    cyc(); chk("R4 wake start", mode, 1);
    for (int i = 0; i < WD; i++) cyc();
    standby_wr = 1; cyc(); standby_wr = 0;
    chk("R6 standby write", mode, 0);
    for (int i = 0; i < 5; i++) cyc();
    chk("R4 held pin no restart", mode, 0);
    wake_pin = 0; cyc(); cyc(); cyc();

    // R2: wake with bad supply
    ext_pwr_n = 1; batt_ok = 1; supply_good = 0;
    wake_pin = 1;
    for (int i = 0; i < 5; i++) cyc();
    chk("R2 wake refused", mode, 0);
    wake_pin = 0; cyc(); cyc(); cyc();
    good_supply();

    // R10: kill blocks start in standby
    irq = 4'b1000; user_rst = 1; cyc(); irq = '0; user_rst = 0;
    chk("R10 user reset blocks start", mode, 0);
    irq = 4'b0100; pwr_fail = 1; cyc(); irq = '0; pwr_fail = 0;
    chk("R10 power fail blocks start", mode, 0);

    // R11: strobes ignored during warm-up, kill honored
    irq = 4'b0010; cyc(); irq = '0;
    halt_wr = 1; cyc(); halt_wr = 0;
    chk_out("R11 halt ignored in warm-up", 1, 1, 0);
    standby_wr = 1; cyc(); standby_wr = 0;
    chk_out("R11 standby ignored in warm-up", 1, 1, 0);
    pwr_fail = 1; cyc(); pwr_fail = 0;
    chk_out("R11 power fail in warm-up", 0, 1, 0);

    // R7/R8: idle and resume
    start_and_warm();
    halt_wr = 1; cyc(); halt_wr = 0;
    chk_out("R7 halt to idle", 2, 0, 0);
    cyc(); chk("R7 idle stays", mode, 2);
    irq = 4'b0100; cyc(); irq = '0;
    chk_out("R8 resume no warm-up", 1, 0, 1);
    halt_wr = 1; cyc(); halt_wr = 0;
    user_rst = 1; cyc(); user_rst = 0;
    chk_out("R8 user reset from idle", 0, 1, 0);

    // R9: priorities
    start_and_warm();
    halt_wr = 1; cyc(); halt_wr = 0;
    pwr_fail = 1; irq = 4'b0001; cyc(); pwr_fail = 0; irq = '0;
    chk("R9 power fail beats irq in idle", mode, 0);
    start_and_warm();
    standby_wr = 1; halt_wr = 1; cyc(); standby_wr = 0; halt_wr = 0;
    chk("R9 standby beats halt", mode, 0);
    start_and_warm();
    user_rst = 1; halt_wr = 1; cyc(); user_rst = 0; halt_wr = 0;
    chk("R9 user reset beats halt", mode, 0);

    // R6: power fail from operating
    start_and_warm();
    pwr_fail = 1; cyc(); pwr_fail = 0;
    chk_out("R6 power fail to standby", 0, 1, 0);

    // R12 covered by every mode check above; final legality check
    chk("R12 mode legal", int'(mode != 2'b11), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule